// File: doc/BRIEF.md
# Register Dependency Scoreboard

This block keeps, for every architectural register, an ordered queue of the in-flight instructions that will write it. Instructions are named by an 8-bit sequence number, where a smaller number means an older instruction. The issue stage inserts an instruction together with its zero, one or two destination registers. Writeback either pops the head of one register's queue or removes an instruction by its number from every register it targets. An execution-status input marks an instruction as executed and records the cycle in which its result becomes available.

Any stage can present one register and its own sequence number and get four answers back from the current state, with no clock in between. The first says whether it may read the register file. The second says whether it may write it. The third names the producer it can forward from, if there is one, which is the youngest queued producer older than the requester whose result was ready before the current cycle. The fourth names the first executed producer behind the head. Each queue has a parameterised depth. An insert that does not fit is refused as a whole and signalled on a stall output. Sequence numbers are compared as plain unsigned values, so every live instruction must lie inside a window that does not wrap.

Top module: `regdep_scoreboard`

## Requirements
- R1: An accepted insert appends one entry per destination to the tail of that register's queue: `dst0` is used when the count field is 1 or more, and `dst1` when it is 2 or 3. Both entries are added if the two destinations are equal. A new entry is not executed.
- R2: Remove-by-number deletes, from each named register, only the entries that carry that number. The remaining entries keep their order. A number that is not queued changes nothing.
- R3: A pop on a register whose queue is non-empty and whose head carries the given number deletes the head. Any other pop leaves the queue unchanged and drives `pop_err_o` high in the following cycle. `pop_err_o` is low in every cycle after a cycle with no failed pop.
- R4: `rd_ok_o` is high when the queried queue is empty or when the requester number is less than or equal to the head number.
- R5: `wr_ok_o` follows the same rule as R4.
- R6: The forwarding candidate is the last entry in a scan from the head that stops at the first entry not older than the requester. `fwd_valid_o` is high only if the candidate is executed and its ready cycle is strictly less than `now_i`. `fwd_seq_o` is then the candidate's number, and 0 otherwise.
- R7: `byp_valid_o` is low when the queue holds fewer than two entries. Otherwise it flags the first executed entry after the head, and `byp_seq_o` gives that entry's number (0 when there is none).
- R8: `stall_o` is high when the queue count at the start of the cycle plus the entries an insert would add exceeds DEPTH for any register. The insert is then refused completely and no queue ever holds more than DEPTH entries.
- R9: Within one cycle, removals and pops are applied first and the insert is appended after them. An execution update in that cycle affects only the entries that survive the removals, never the entries being inserted.
- R10: Synchronous reset or `clr_i` empties every queue and clears `pop_err_o`. All other inputs in that cycle are ignored.
- R11: An execution update marks every queued entry carrying its number as executed and overwrites that entry's ready cycle with `exe_cycle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Empty all queues |
| ins_valid_i | input | 1 | Insert request |
| ins_ndst_i | input | 2 | Number of destinations (0..2, 3 acts as 2) |
| ins_seq_i | input | SEQ_W | Inserted instruction number |
| ins_dst0_i | input | RW | First destination register |
| ins_dst1_i | input | RW | Second destination register |
| stall_o | output | 1 | Insert refused, a queue would overflow |
| rm_valid_i | input | 1 | Remove-by-number request |
| rm_ndst_i | input | 2 | Number of registers named by the remove |
| rm_seq_i | input | SEQ_W | Number to remove |
| rm_dst0_i | input | RW | First register to search |
| rm_dst1_i | input | RW | Second register to search |
| pop_valid_i | input | 1 | Pop-head request |
| pop_reg_i | input | RW | Register whose head is popped |
| pop_seq_i | input | SEQ_W | Number expected at the head |
| pop_err_o | output | 1 | Previous cycle's pop did not match |
| exe_valid_i | input | 1 | Execution update |
| exe_seq_i | input | SEQ_W | Executed instruction number |
| exe_cycle_i | input | CYC_W | Cycle in which its result is ready |
| now_i | input | CYC_W | Current cycle number |
| q_reg_i | input | RW | Queried register |
| q_seq_i | input | SEQ_W | Requester number |
| q_cnt_o | output | CNT_W | Entries queued on the queried register |
| rd_ok_o | output | 1 | Register-file read permitted |
| wr_ok_o | output | 1 | Register-file write permitted |
| fwd_valid_o | output | 1 | Forwarding producer available |
| fwd_seq_o | output | SEQ_W | Forwarding producer number |
| byp_valid_o | output | 1 | Executed producer behind the head found |
| byp_seq_o | output | SEQ_W | Its number |

## Verification
A lost or misordered queue entry shows up at once in the combinational answers for the register being queried. A wrong count changes `q_cnt_o` and the stall decision. A wrong head flips `rd_ok_o` and `wr_ok_o` for requesters near the head number. A stale executed flag or ready cycle changes the forward and bypass answers. Because the bench compares every answer with a behavioural queue model on every cycle, while rotating the queried register and requester number, a corrupted entry is reported in the first cycle in which any query touches that register. For registered `pop_err_o` this is one cycle after the pop that went wrong.

// File: rtl/dep_pkg.sv
package dep_pkg;

  // Number of entries an operation adds to or names in a register,
  // given the destination count and which destination slots match it.
  function automatic logic [1:0] dst_hits(input logic [1:0] ndst,
                                          input logic       m0,
                                          input logic       m1);
    logic [1:0] a;
    logic [1:0] b;
    a = {1'b0, (ndst != 2'd0) && m0};
    b = {1'b0, (ndst >= 2'd2) && m1};
    return a + b;
  endfunction

endpackage

// File: rtl/dep_queue.sv
module dep_queue #(
  parameter  int DEPTH = 4,
  parameter  int SEQ_W = 8,
  parameter  int CYC_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              rm_hit,
  input  logic [SEQ_W-1:0]                  rm_seq,
  input  logic                              pop_hit,
  input  logic [SEQ_W-1:0]                  pop_seq,
  input  logic                              exe_valid,
  input  logic [SEQ_W-1:0]                  exe_seq,
  input  logic [CYC_W-1:0]                  exe_cycle,
  input  logic [1:0]                        push_n,
  input  logic [SEQ_W-1:0]                  push_seq,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]       seq_o,
  output logic [DEPTH-1:0]                  exe_o,
  output logic [DEPTH-1:0][CYC_W-1:0]       rdy_o,
  output logic                              pop_bad_o
);

  logic [CNT_W-1:0]                cnt_q, cnt_d, wr;
  logic [DEPTH-1:0][SEQ_W-1:0]     seq_q, seq_d;
  logic [DEPTH-1:0]                exe_q, exe_d;
  logic [DEPTH-1:0][CYC_W-1:0]     rdy_q, rdy_d;
  logic                            pop_take;
  logic                            keep;

  // Next state: drop removed / popped entries and compact, then append.
  always_comb begin
    pop_take  = pop_hit && (cnt_q != '0) && (seq_q[0] == pop_seq);
    pop_bad_o = pop_hit && !pop_take;
    seq_d = '0;
    exe_d = '0;
    rdy_d = '0;
    wr    = '0;
    keep  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      keep = (CNT_W'(i) < cnt_q) && !(rm_hit && (seq_q[i] == rm_seq)) &&
             !((i == 0) && pop_take);
      if (keep) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (CNT_W'(j) == wr) begin
            seq_d[j] = seq_q[i];
            exe_d[j] = exe_q[i];
            rdy_d[j] = rdy_q[i];
            if (exe_valid && (seq_q[i] == exe_seq)) begin
              exe_d[j] = 1'b1;
              rdy_d[j] = exe_cycle;
            end
          end
        end
        wr = wr + 1'b1;
      end
    end
    for (int k = 0; k < 2; k++) begin
      if ((2'(k) < push_n) && (wr < CNT_W'(DEPTH))) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (CNT_W'(j) == wr) seq_d[j] = push_seq;
        end
        wr = wr + 1'b1;
      end
    end
    cnt_d = wr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      seq_q <= '0;
      exe_q <= '0;
      rdy_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      seq_q <= seq_d;
      exe_q <= exe_d;
      rdy_q <= rdy_d;
    end
  end

  assign cnt_o = cnt_q;
  assign seq_o = seq_q;
  assign exe_o = exe_q;
  assign rdy_o = rdy_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH)); // R8
  AST_POP_BAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (pop_bad_o && !rm_hit && (push_n == 2'd0) && !clr) |=> (cnt_q == $past(cnt_q))); // R3
  AST_POP_TAKES_ONE: assert property (@(posedge clk) disable iff (rst)
    (pop_take && !rm_hit && (push_n == 2'd0) && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/dep_query.sv
module dep_query #(
  parameter  int DEPTH = 4,
  parameter  int SEQ_W = 8,
  parameter  int CYC_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]            cnt,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
  input  logic [DEPTH-1:0]            exe,
  input  logic [DEPTH-1:0][CYC_W-1:0] rdy,
  input  logic [SEQ_W-1:0]            q_seq,
  input  logic [CYC_W-1:0]            now,
  output logic                        rd_ok,
  output logic                        wr_ok,
  output logic                        fwd_valid,
  output logic [SEQ_W-1:0]            fwd_seq,
  output logic                        byp_valid,
  output logic [SEQ_W-1:0]            byp_seq
);

  logic             head_ok, scan, found, c_exe;
  logic [SEQ_W-1:0] c_seq;
  logic [CYC_W-1:0] c_rdy;

  always_comb begin
    head_ok = (cnt == '0) || (q_seq <= seq[0]);
    rd_ok   = head_ok;
    wr_ok   = head_ok;

    // Walk from the head while entries are older than the requester.
    scan  = 1'b1;
    found = 1'b0;
    c_seq = '0;
    c_exe = 1'b0;
    c_rdy = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (scan && (CNT_W'(i) < cnt) && (seq[i] < q_seq)) begin
        found = 1'b1;
        c_seq = seq[i];
        c_exe = exe[i];
        c_rdy = rdy[i];
      end else begin
        scan = 1'b0;
      end
    end
    fwd_valid = found && c_exe && (c_rdy < now);
    fwd_seq   = fwd_valid ? c_seq : '0;

    // First executed entry behind the head.
    byp_valid = 1'b0;
    byp_seq   = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (!byp_valid && (CNT_W'(i) < cnt) && exe[i]) begin
        byp_valid = 1'b1;
        byp_seq   = seq[i];
      end
    end
  end

endmodule

// File: rtl/regdep_scoreboard.sv
module regdep_scoreboard
  import dep_pkg::*;
#(
  parameter  int NREG  = 8,
  parameter  int DEPTH = 4,
  parameter  int SEQ_W = 8,
  parameter  int CYC_W = 16,
  localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              ins_valid_i,
  input  logic [1:0]        ins_ndst_i,
  input  logic [SEQ_W-1:0]  ins_seq_i,
  input  logic [RW-1:0]     ins_dst0_i,
  input  logic [RW-1:0]     ins_dst1_i,
  output logic              stall_o,
  input  logic              rm_valid_i,
  input  logic [1:0]        rm_ndst_i,
  input  logic [SEQ_W-1:0]  rm_seq_i,
  input  logic [RW-1:0]     rm_dst0_i,
  input  logic [RW-1:0]     rm_dst1_i,
  input  logic              pop_valid_i,
  input  logic [RW-1:0]     pop_reg_i,
  input  logic [SEQ_W-1:0]  pop_seq_i,
  output logic              pop_err_o,
  input  logic              exe_valid_i,
  input  logic [SEQ_W-1:0]  exe_seq_i,
  input  logic [CYC_W-1:0]  exe_cycle_i,
  input  logic [CYC_W-1:0]  now_i,
  input  logic [RW-1:0]     q_reg_i,
  input  logic [SEQ_W-1:0]  q_seq_i,
  output logic [CNT_W-1:0]  q_cnt_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              fwd_valid_o,
  output logic [SEQ_W-1:0]  fwd_seq_o,
  output logic              byp_valid_o,
  output logic [SEQ_W-1:0]  byp_seq_o
);

  logic [NREG-1:0]              rm_hit, pop_hit, over, bad;
  logic [1:0]                   push_raw [NREG];
  logic [CNT_W-1:0]             cnt_a    [NREG];
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_a    [NREG];
  logic [DEPTH-1:0]             exe_a    [NREG];
  logic [DEPTH-1:0][CYC_W-1:0]  rdy_a    [NREG];

  logic [DEPTH-1:0][SEQ_W-1:0]  sel_seq;
  logic [DEPTH-1:0]             sel_exe;
  logic [DEPTH-1:0][CYC_W-1:0]  sel_rdy;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign rm_hit[g]   = rm_valid_i &&
                         (dst_hits(rm_ndst_i, rm_dst0_i == RW'(g), rm_dst1_i == RW'(g)) != 2'd0);
    assign push_raw[g] = ins_valid_i ?
                         dst_hits(ins_ndst_i, ins_dst0_i == RW'(g), ins_dst1_i == RW'(g)) : 2'd0;
    assign pop_hit[g]  = pop_valid_i && (pop_reg_i == RW'(g));
    assign over[g]     = (32'(cnt_a[g]) + 32'(push_raw[g])) > DEPTH;

    dep_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CYC_W(CYC_W)) i_queue (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_i),
      .rm_hit    (rm_hit[g]),
      .rm_seq    (rm_seq_i),
      .pop_hit   (pop_hit[g]),
      .pop_seq   (pop_seq_i),
      .exe_valid (exe_valid_i),
      .exe_seq   (exe_seq_i),
      .exe_cycle (exe_cycle_i),
      .push_n    (stall_o ? 2'd0 : push_raw[g]),
      .push_seq  (ins_seq_i),
      .cnt_o     (cnt_a[g]),
      .seq_o     (seq_a[g]),
      .exe_o     (exe_a[g]),
      .rdy_o     (rdy_a[g]),
      .pop_bad_o (bad[g])
    );
  end

  // The insert is all-or-nothing.
  assign stall_o = |over;

  always_ff @(posedge clk) begin
    if (rst || clr_i) pop_err_o <= 1'b0;
    else              pop_err_o <= |bad;
  end

  // Select the queried register's queue.
  always_comb begin
    q_cnt_o = '0;
    sel_seq = '0;
    sel_exe = '0;
    sel_rdy = '0;
    for (int r = 0; r < NREG; r++) begin
      if (q_reg_i == RW'(r)) begin
        q_cnt_o = cnt_a[r];
        sel_seq = seq_a[r];
        sel_exe = exe_a[r];
        sel_rdy = rdy_a[r];
      end
    end
  end

  dep_query #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CYC_W(CYC_W)) i_query (
    .cnt       (q_cnt_o),
    .seq       (sel_seq),
    .exe       (sel_exe),
    .rdy       (sel_rdy),
    .q_seq     (q_seq_i),
    .now       (now_i),
    .rd_ok     (rd_ok_o),
    .wr_ok     (wr_ok_o),
    .fwd_valid (fwd_valid_o),
    .fwd_seq   (fwd_seq_o),
    .byp_valid (byp_valid_o),
    .byp_seq   (byp_seq_o)
  );

  AST_EMPTY_OPEN: assert property (@(posedge clk) disable iff (rst)
    (q_cnt_o == '0) |-> (rd_ok_o && wr_ok_o && !fwd_valid_o && !byp_valid_o)); // R4
  AST_FWD_OLDER: assert property (@(posedge clk) disable iff (rst)
    fwd_valid_o |-> (fwd_seq_o < q_seq_i)); // R6
  AST_BYP_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    byp_valid_o |-> (q_cnt_o >= CNT_W'(2))); // R7
  AST_STALL_ON_INSERT: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> ins_valid_i); // R8
  AST_POP_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pop_err_o |-> $past(pop_valid_i)); // R3

endmodule

// File: tb/test_regdep_scoreboard.sv
`timescale 1ns/1ps
module test_regdep_scoreboard;

  localparam int NREG  = 8;
  localparam int DEPTH = 4;
  localparam int SEQ_W = 8;
  localparam int CYC_W = 16;
  localparam int RW    = 3;
  localparam int CNT_W = 3;
  localparam int LMAX  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_i = 1'b0;
  logic ins_valid_i = 1'b0;
  logic [1:0] ins_ndst_i = '0;
  logic [SEQ_W-1:0] ins_seq_i = '0;
  logic [RW-1:0] ins_dst0_i = '0, ins_dst1_i = '0;
  logic rm_valid_i = 1'b0;
  logic [1:0] rm_ndst_i = '0;
  logic [SEQ_W-1:0] rm_seq_i = '0;
  logic [RW-1:0] rm_dst0_i = '0, rm_dst1_i = '0;
  logic pop_valid_i = 1'b0;
  logic [RW-1:0] pop_reg_i = '0;
  logic [SEQ_W-1:0] pop_seq_i = '0;
  logic exe_valid_i = 1'b0;
  logic [SEQ_W-1:0] exe_seq_i = '0;
  logic [CYC_W-1:0] exe_cycle_i = '0;
  logic [CYC_W-1:0] now_i = '0;
  logic [RW-1:0] q_reg_i = '0;
  logic [SEQ_W-1:0] q_seq_i = '0;
  logic stall_o, pop_err_o, rd_ok_o, wr_ok_o, fwd_valid_o, byp_valid_o;
  logic [CNT_W-1:0] q_cnt_o;
  logic [SEQ_W-1:0] fwd_seq_o, byp_seq_o;

  always #2 clk = ~clk;

  regdep_scoreboard #(.NREG(NREG), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CYC_W(CYC_W))
  i_regdep_scoreboard (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .ins_valid_i(ins_valid_i), .ins_ndst_i(ins_ndst_i), .ins_seq_i(ins_seq_i),
    .ins_dst0_i(ins_dst0_i), .ins_dst1_i(ins_dst1_i), .stall_o(stall_o),
    .rm_valid_i(rm_valid_i), .rm_ndst_i(rm_ndst_i), .rm_seq_i(rm_seq_i),
    .rm_dst0_i(rm_dst0_i), .rm_dst1_i(rm_dst1_i),
    .pop_valid_i(pop_valid_i), .pop_reg_i(pop_reg_i), .pop_seq_i(pop_seq_i),
    .pop_err_o(pop_err_o),
    .exe_valid_i(exe_valid_i), .exe_seq_i(exe_seq_i), .exe_cycle_i(exe_cycle_i),
    .now_i(now_i), .q_reg_i(q_reg_i), .q_seq_i(q_seq_i), .q_cnt_o(q_cnt_o),
    .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .fwd_valid_o(fwd_valid_o),
    .fwd_seq_o(fwd_seq_o), .byp_valid_o(byp_valid_o), .byp_seq_o(byp_seq_o)
  );

  // Reference model: per-register queues held as fixed arrays with counts.
  int ms [NREG][DEPTH];
  bit me [NREG][DEPTH];
  int mr [NREG][DEPTH];
  int mc [NREG];
  bit perr_exp;
  int lv_seq [LMAX];
  int lv_n [LMAX];
  int lv_d0 [LMAX];
  int lv_d1 [LMAX];
  int nlive;
  int nseq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int hits(input int n, input int d0, input int d1, input int r);
    int h = 0;
    if (n >= 1 && d0 == r) h++;
    if (n >= 2 && d1 == r) h++;
    return h;
  endfunction

  function automatic bit model_stall();
    bit s = 0;
    if (ins_valid_i)
      for (int r = 0; r < NREG; r++)
        if (mc[r] + hits(int'(ins_ndst_i), int'(ins_dst0_i), int'(ins_dst1_i), r) > DEPTH) s = 1;
    return s;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) mc[r] = 0;
    perr_exp = 0;
    nlive = 0;
  endtask

  task automatic check_all();
    int r, c, cand;
    bit rd, fv, bv;
    int fs, bs;
    r = int'(q_reg_i);
    c = mc[r];
    rd = (c == 0) || (int'(q_seq_i) <= ms[r][0]);
    cand = -1;
    for (int i = 0; i < c; i++) begin
      if (ms[r][i] < int'(q_seq_i)) cand = i;
      else break;
    end
    fv = (cand >= 0) && me[r][cand] && (mr[r][cand] < int'(now_i));
    fs = fv ? ms[r][cand] : 0;
    bv = 0; bs = 0;
    for (int i = 1; i < c; i++) begin
      if (me[r][i]) begin bv = 1; bs = ms[r][i]; break; end
    end
    chk("R8 stall", int'(stall_o), int'(model_stall()));
    chk("R3 pop_err", int'(pop_err_o), int'(perr_exp));
    chk("R1 R2 R9 R10 count", int'(q_cnt_o), c);
    chk("R4 rd_ok", int'(rd_ok_o), int'(rd));
    chk("R5 wr_ok", int'(wr_ok_o), int'(rd));
    chk("R6 R11 fwd_valid", int'(fwd_valid_o), int'(fv));
    chk("R6 R11 fwd_seq", int'(fwd_seq_o), fs);
    chk("R7 R11 byp_valid", int'(byp_valid_o), int'(bv));
    chk("R7 byp_seq", int'(byp_seq_o), bs);
  endtask

  task automatic model_update();
    int ns [DEPTH];
    bit ne [DEPTH];
    int nr [DEPTH];
    int w, pr, add;
    bit stall, take, rmh;
    if (clr_i) begin model_clear(); return; end
    stall = model_stall();
    pr = int'(pop_reg_i);
    take = pop_valid_i && mc[pr] > 0 && ms[pr][0] == int'(pop_seq_i);
    perr_exp = pop_valid_i && !take;
    for (int r = 0; r < NREG; r++) begin
      rmh = rm_valid_i && hits(int'(rm_ndst_i), int'(rm_dst0_i), int'(rm_dst1_i), r) > 0;
      w = 0;
      for (int i = 0; i < mc[r]; i++) begin
        if (rmh && ms[r][i] == int'(rm_seq_i)) continue;
        if (i == 0 && take && pr == r) continue;
        ns[w] = ms[r][i]; ne[w] = me[r][i]; nr[w] = mr[r][i];
        if (exe_valid_i && ms[r][i] == int'(exe_seq_i)) begin
          ne[w] = 1; nr[w] = int'(exe_cycle_i);
        end
        w++;
      end
      add = stall ? 0 : (ins_valid_i ? hits(int'(ins_ndst_i), int'(ins_dst0_i), int'(ins_dst1_i), r) : 0);
      for (int k = 0; k < add; k++) begin
        ns[w] = int'(ins_seq_i); ne[w] = 0; nr[w] = 0; w++;
      end
      for (int i = 0; i < w; i++) begin
        ms[r][i] = ns[i]; me[r][i] = ne[i]; mr[r][i] = nr[i];
      end
      mc[r] = w;
    end
    if (rm_valid_i) begin
      for (int i = 0; i < nlive; i++) begin
        if (lv_seq[i] == int'(rm_seq_i)) begin
          lv_seq[i] = lv_seq[nlive-1]; lv_n[i] = lv_n[nlive-1];
          lv_d0[i] = lv_d0[nlive-1]; lv_d1[i] = lv_d1[nlive-1];
          nlive--;
          break;
        end
      end
    end
    if (ins_valid_i && !stall && ins_ndst_i != 0 && nlive < LMAX) begin
      lv_seq[nlive] = int'(ins_seq_i); lv_n[nlive] = int'(ins_ndst_i);
      lv_d0[nlive] = int'(ins_dst0_i); lv_d1[nlive] = int'(ins_dst1_i);
      nlive++;
    end
  endtask

  // Called just after a falling edge with the inputs already set.
  task automatic step();
    #1;
    check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    now_i = now_i + 1'b1;
  endtask

  task automatic idle();
    clr_i = 0; ins_valid_i = 0; rm_valid_i = 0; pop_valid_i = 0; exe_valid_i = 0;
  endtask

  task automatic ins(input int s, input int n, input int d0, input int d1);
    ins_valid_i = 1; ins_seq_i = SEQ_W'(s); ins_ndst_i = 2'(n);
    ins_dst0_i = RW'(d0); ins_dst1_i = RW'(d1);
  endtask

  task automatic rmv(input int s, input int n, input int d0, input int d1);
    rm_valid_i = 1; rm_seq_i = SEQ_W'(s); rm_ndst_i = 2'(n);
    rm_dst0_i = RW'(d0); rm_dst1_i = RW'(d1);
  endtask

  task automatic pop(input int r, input int s);
    pop_valid_i = 1; pop_reg_i = RW'(r); pop_seq_i = SEQ_W'(s);
  endtask

  task automatic exe(input int s, input int cyc);
    exe_valid_i = 1; exe_seq_i = SEQ_W'(s); exe_cycle_i = CYC_W'(cyc);
  endtask

  task automatic qry(input int r, input int s);
    q_reg_i = RW'(r); q_seq_i = SEQ_W'(s);
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R10: state right after reset, every register empty.
    for (int r = 0; r < NREG; r++) begin qry(r, 5); step(); end

    // R1: fill register 3 with 1, 2, 3, 3 (dual destination on one register).
    ins(1, 2, 3, 5); qry(3, 9); step(); idle();
    ins(2, 1, 3, 0); step(); idle();
    ins(3, 2, 3, 3); step(); idle();
    qry(3, 1); step();
    qry(5, 1); step();
    // R8: register 3 full, insert refused as a whole (reg 6 stays empty).
    ins(4, 2, 6, 3); qry(6, 9); step(); idle();
    qry(6, 9); step();
    // R4 / R5 boundaries against head 1.
    qry(3, 0); step();
    qry(3, 2); step();
    // R11 then R6: executed with ready cycle equal to now, then one later.
    exe(2, int'(now_i)); qry(3, 3); step(); idle();
    qry(3, 3); step();
    qry(3, 3); step();
    qry(3, 2); step();
    // R7: first executed entry behind the head.
    qry(3, 0); step();
    // R2: remove seq 2 from register 3; then an unknown number.
    rmv(2, 1, 3, 0); step(); idle();
    qry(3, 3); step();
    rmv(9, 2, 3, 5); step(); idle();
    qry(3, 3); step();
    // R3: pop with a non-head number fails, then a matching pop.
    pop(3, 3); step(); idle();
    step();
    pop(3, 1); step(); idle();
    qry(3, 9); step();
    pop(7, 1); step(); idle();
    step();
    // R9: pop head and insert in one cycle, exe of the inserted number ignored.
    ins(10, 1, 2, 0); step(); idle();
    pop(2, 10); ins(11, 1, 2, 0); exe(11, 0); qry(2, 20); step(); idle();
    qry(2, 20); step();
    step();
    // R10: clear empties everything.
    clr_i = 1; ins(12, 1, 4, 0); step(); idle();
    for (int r = 0; r < NREG; r++) begin qry(r, 3); step(); end

    // Random traffic across four registers.
    model_clear();
    nseq = 1;
    for (int t = 0; t < 1500; t++) begin
      idle();
      if (nseq > 240) begin
        clr_i = 1; nseq = 1;
      end else begin
        if ($urandom % 2 == 0 && nlive < LMAX) begin
          ins(nseq, $urandom % 3, $urandom % 4, $urandom % 4);
          nseq++;
        end
        if ($urandom % 4 == 0 && nlive > 0) begin
          int k = $urandom % nlive;
          rmv(lv_seq[k], lv_n[k], lv_d0[k], lv_d1[k]);
        end
        if ($urandom % 4 == 0) begin
          int r = $urandom % 4;
          if (mc[r] > 0 && $urandom % 3 != 0) pop(r, ms[r][0]);
          else pop(r, $urandom % (nseq + 1));
        end
        if ($urandom % 3 == 0 && nlive > 0) begin
          int c = int'(now_i) + int'($urandom % 3) - 1;
          exe(lv_seq[$urandom % nlive], (c < 0) ? 0 : c);
        end
      end
      qry($urandom % 5, $urandom % (nseq + 2));
      step();
    end
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule